// File: doc/BRIEF.md
# Lane-Preserving Thread Compactor

After a branch, only some threads of a thread block follow a given path. This block takes the block-wide active mask for one path, laid out as static warps by lanes, together with the thread ID held in every slot. It regroups the active threads into as few dense dynamic warps as possible and hands them out one warp per handshake to a warp buffer. Compaction runs separately in each lane across all static warps, so a thread never leaves its home lane and the register file banking stays as it was. When every thread is active, the output is the original static warp arrangement, in the original order.

A mask is taken when `in_valid` and `in_ready` are both high. Warps are then offered on `out_valid`/`out_ready`. One cycle after the last warp is accepted, `done` pulses and the block is ready for the next mask. The controller has three states. IDLE accepts a mask: it goes to EMIT if the mask has any active thread, or straight to DONE if the mask is empty. EMIT stays in EMIT while threads remain or the output is stalled, and goes to DONE once the final warp is accepted. DONE returns to IDLE after one cycle.

Top module: `thread_compactor`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: Active-mask bit `w*LANES + l` and thread-ID slice `w*LANES + l` (each TID_W bits wide) describe the thread in static warp `w`, lane `l`. Output lane `l` (bit `l` of `out_lane_valid`, slice `l` of `out_tid`) only ever carries a thread that came from lane `l`.
- R3: Within each lane, the active threads are emitted in increasing static-warp order, one per output warp.
- R4: The number of warps emitted for a mask equals the largest count of active threads found in any single lane.
- R5: An output lane with no remaining thread has its `out_lane_valid` bit at 0 and its `out_tid` slice at 0.
- R6: With every mask bit set, the emitted warps are the static warps in order 0, 1, 2, ….
- R7: While `out_valid` is high and `out_ready` is low, the offered warp holds unchanged and no thread is lost.
- R8: `done` is high for exactly one cycle. That cycle is the one after the final warp is accepted, or the one after an empty mask is taken.
- R9: `in_ready` is low from the cycle after a mask is taken until `done` has pulsed. A mask presented while busy is ignored.
- R10: Every offered warp has at least one valid lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A mask and its thread IDs are offered |
| in_ready | output | 1 | Block is idle and takes the offered mask |
| in_mask | input | WARPS*LANES | Active bit per thread slot, bit w*LANES+l |
| in_tid | input | WARPS*LANES*TID_W | Thread ID per slot, slice w*LANES+l |
| out_valid | output | 1 | A compacted warp is offered |
| out_ready | input | 1 | Warp buffer accepts the offered warp |
| out_lane_valid | output | LANES | Per-lane valid bit of the offered warp |
| out_tid | output | LANES*TID_W | Per-lane thread ID of the offered warp |
| done | output | 1 | Pulses once after a mask is fully compacted |

## Verification
The assertions check on every cycle that a stalled warp and its remaining threads hold still, that no offered warp is empty, that `done` is a single-cycle pulse followed by readiness, and that no new mask is taken while busy. Whether each lane keeps its own threads in static-warp order, whether the warp count matches the busiest lane, and whether a full mask reproduces the static layout can only be shown by the bench. It compares against a per-lane queue model under empty, full, sparse, single-lane and random masks with varied backpressure.

// File: rtl/compactor_pkg.sv
package compactor_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EMIT = 2'd1,
        ST_DONE = 2'd2
    } comp_state_e;
endpackage

// File: rtl/compactor_lane_pick.sv
// Picks the lowest-numbered static warp that still holds an active thread in one lane.
module compactor_lane_pick #(
    parameter int WARPS = 4,
    parameter int TID_W = 8
) (
    input  logic [WARPS-1:0]       column,
    input  logic [WARPS*TID_W-1:0] column_tid,
    output logic                   pick_valid,
    output logic [WARPS-1:0]       pick_grant,
    output logic [TID_W-1:0]       pick_tid
);
    always_comb begin
        pick_valid = 1'b0;
        pick_grant = '0;
        pick_tid   = '0;
        for (int w = 0; w < WARPS; w++) begin
            if (column[w] && !pick_valid) begin
                pick_valid    = 1'b1;
                pick_grant[w] = 1'b1;
                pick_tid      = column_tid[w*TID_W +: TID_W];
            end
        end
    end
endmodule

// File: rtl/compactor_fsm.sv
module compactor_fsm
    import compactor_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic load_empty,
    input  logic warp_fire,
    input  logic warp_last,
    output logic in_ready,
    output logic emit,
    output logic done,
    output logic load
);
    comp_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (in_valid) state_d = load_empty ? ST_DONE : ST_EMIT;
            ST_EMIT: if (warp_fire && warp_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        in_ready = 1'b0;
        emit     = 1'b0;
        done     = 1'b0;
        unique case (state_q)
            ST_IDLE: in_ready = 1'b1;
            ST_EMIT: emit     = 1'b1;
            ST_DONE: done     = 1'b1;
            default: ;
        endcase
        load = in_ready && in_valid;
    end

    // R8: done is a single pulse and is followed by readiness
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && in_ready));
    // R9: after a mask is taken the block stops taking masks
    assert_busy_after_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);
endmodule

// File: rtl/thread_compactor.sv
module thread_compactor
    import compactor_pkg::*;
#(
    parameter int WARPS = 4,
    parameter int LANES = 4,
    parameter int TID_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [WARPS*LANES-1:0]       in_mask,
    input  logic [WARPS*LANES*TID_W-1:0] in_tid,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [LANES-1:0]             out_lane_valid,
    output logic [LANES*TID_W-1:0]       out_tid,
    output logic                         done
);
    localparam int SLOTS = WARPS * LANES;

    logic [SLOTS-1:0]       rem_q;
    logic [SLOTS*TID_W-1:0] tid_q;
    logic [SLOTS-1:0]       taken;
    logic [SLOTS-1:0]       rem_after;
    logic                   emit, load, warp_fire, warp_last;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [WARPS-1:0]       column;
        logic [WARPS*TID_W-1:0] column_tid;
        logic [WARPS-1:0]       grant;
        for (genvar w = 0; w < WARPS; w++) begin : g_warp
            assign column[w]                        = rem_q[w*LANES + l];
            assign column_tid[w*TID_W +: TID_W]     = tid_q[(w*LANES + l)*TID_W +: TID_W];
            assign taken[w*LANES + l]               = grant[w];
        end
        compactor_lane_pick #(.WARPS(WARPS), .TID_W(TID_W)) pick_i (
            .column     (column),
            .column_tid (column_tid),
            .pick_valid (out_lane_valid[l]),
            .pick_grant (grant),
            .pick_tid   (out_tid[l*TID_W +: TID_W])
        );
    end

    assign rem_after = rem_q & ~taken;
    assign warp_fire = out_valid && out_ready;
    assign warp_last = (rem_after == '0);
    assign out_valid = emit;

    compactor_fsm fsm_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .load_empty (in_mask == '0),
        .warp_fire  (warp_fire),
        .warp_last  (warp_last),
        .in_ready   (in_ready),
        .emit       (emit),
        .done       (done),
        .load       (load)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q <= '0;
            tid_q <= '0;
        end else if (load) begin
            rem_q <= in_mask;
            tid_q <= in_tid;
        end else if (warp_fire) begin
            rem_q <= rem_after;
        end
    end

    // R7: a stalled warp holds still and keeps all its remaining threads
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_tid)
                                       && $stable(out_lane_valid) && $stable(rem_q)));
    // R10: no empty warp is ever offered
    assert_nonempty_warp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_lane_valid != '0));
    // R9: output and input sides are never active together
    assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !in_ready);
endmodule

// File: tb/thread_compactor_tb_top.sv
module thread_compactor_tb_top;
    localparam int WARPS = 4;
    localparam int LANES = 4;
    localparam int TID_W = 8;
    localparam int SLOTS = WARPS * LANES;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [SLOTS-1:0] in_mask = '0;
    logic [SLOTS*TID_W-1:0] in_tid = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [LANES-1:0] out_lane_valid;
    logic [LANES*TID_W-1:0] out_tid;
    logic done;

    always #2.5 clk = ~clk;

    thread_compactor #(.WARPS(WARPS), .LANES(LANES), .TID_W(TID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_mask(in_mask), .in_tid(in_tid), .out_valid(out_valid),
        .out_ready(out_ready), .out_lane_valid(out_lane_valid),
        .out_tid(out_tid), .done(done)
    );

    int checks = 0;
    int fails = 0;
    bit finished = 0;

    // Reference model: one queue of thread IDs per lane, filled in static-warp order.
    int lane_q[LANES][$];
    int m_state = 0;      // 0 idle, 1 emitting, 2 done
    int m_warps = 0;
    int done_seen = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0;
            for (int l = 0; l < LANES; l++) lane_q[l].delete();
        end else begin
            case (m_state)
                0: if (in_valid) begin
                    int any;
                    any = 0;
                    m_warps = 0;
                    for (int w = 0; w < WARPS; w++)
                        for (int l = 0; l < LANES; l++)
                            if (in_mask[w*LANES + l]) begin
                                lane_q[l].push_back(int'(in_tid[(w*LANES + l)*TID_W +: TID_W]));
                                any = 1;
                            end
                    m_state = any ? 1 : 2;
                end
                1: if (out_ready) begin
                    int left;
                    left = 0;
                    m_warps++;
                    for (int l = 0; l < LANES; l++) begin
                        if (lane_q[l].size() > 0) void'(lane_q[l].pop_front());
                        left += lane_q[l].size();
                    end
                    if (left == 0) m_state = 2;
                end
                default: m_state = 0;
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        check(in_ready == (m_state == 0), "R9", "in_ready", in_ready, m_state == 0);
        check(out_valid == (m_state == 1), "R4", "out_valid", out_valid, m_state == 1);
        check(done == (m_state == 2), "R8", "done", done, m_state == 2);
        if (done) done_seen++;
        if (m_state == 1) begin
            for (int l = 0; l < LANES; l++) begin
                bit has;
                int et;
                has = lane_q[l].size() > 0;
                et = has ? lane_q[l][0] : 0;
                check(out_lane_valid[l] == has, "R5", "lane valid", out_lane_valid[l], has);
                check(int'(out_tid[l*TID_W +: TID_W]) == et, "R2 R3", "lane tid",
                      out_tid[l*TID_W +: TID_W], et);
            end
            check(out_lane_valid != '0, "R10", "nonempty warp", out_lane_valid, 1);
        end
    endtask

    task automatic tick(input int ready_mode);
        @(negedge clk);
        compare();
        case (ready_mode)
            0: out_ready = 1'b1;
            1: out_ready = 1'($urandom_range(1, 0));
            default: out_ready = ~out_ready;
        endcase
    endtask

    function automatic int busiest_lane(input logic [SLOTS-1:0] m);
        int best;
        best = 0;
        for (int l = 0; l < LANES; l++) begin
            int c;
            c = 0;
            for (int w = 0; w < WARPS; w++) c += int'(m[w*LANES + l]);
            if (c > best) best = c;
        end
        return best;
    endfunction

    // Presents one mask, keeps in_valid high with junk while busy (must be ignored),
    // drops it on the done cycle and waits for idle.
    task automatic run_job(input logic [SLOTS-1:0] m, input logic [SLOTS*TID_W-1:0] t,
                           input int ready_mode, input string tag);
        bit taken;
        taken = 0;
        done_seen = 0;
        @(negedge clk);
        compare();
        in_valid = 1'b1;
        in_mask = m;
        in_tid = t;
        forever begin
            tick(ready_mode);
            if (m_state != 0) taken = 1;
            if (taken && m_state == 1) begin
                in_mask = ~m;
                in_tid = ~t;
            end
            if (m_state == 2) in_valid = 1'b0;
            if (taken && m_state == 0) break;
        end
        check(m_warps == busiest_lane(m), "R4", {tag, " warp count"}, m_warps, busiest_lane(m));
        check(done_seen == 1, "R8", {tag, " done pulses"}, done_seen, 1);
    endtask

    function automatic logic [SLOTS*TID_W-1:0] seq_tids();
        logic [SLOTS*TID_W-1:0] t;
        for (int s = 0; s < SLOTS; s++) t[s*TID_W +: TID_W] = TID_W'(s + 1);
        return t;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R1", "reset out_valid", out_valid, 0);
        check(done == 1'b0, "R1", "reset done", done, 0);

        // R6: full mask reproduces static warps in order
        run_job('1, seq_tids(), 0, "R6 full");
        // split-path example: warps {1,2,7,8} then {5,-,11,12}
        run_job(16'h0CD3, seq_tids(), 0, "R3 example");
        // R8: empty mask gives done with no warps
        run_job('0, seq_tids(), 0, "R8 empty");
        // single thread
        run_job(16'h0400, seq_tids(), 2, "R5 single");
        // one lane in every warp, stalled output (R7)
        run_job(16'h2222, seq_tids(), 2, "R7 one lane");
        run_job('1, seq_tids(), 1, "R7 full random stall");
        for (int i = 0; i < 60; i++) begin
            logic [SLOTS*TID_W-1:0] t;
            for (int s = 0; s < SLOTS; s++) t[s*TID_W +: TID_W] = TID_W'($urandom);
            run_job(SLOTS'($urandom), t, i % 3, "R4 random");
        end
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule